// File: doc/BRIEF.md
# Striped DMA Request Splitter Scoreboard

This block sits between a control processor and the memory side of a storage node. It accepts a large data-movement request (start byte address, byte length, parent ID). It cuts the request into pieces of at most one chunk (2 KB by default). The first piece is shortened so that every later piece starts on a chunk boundary. Because a chunk is never larger than an 8 KB slice, no piece spans two slices.

The global address space is interleaved across four banks in 8 KB slices. The bank of a piece is taken from address bits [14:13]. If that bank equals this node's own bank number, the piece goes to the local controller port. Otherwise it goes to the remote port, which also carries the bank number. Pieces are issued back to back without waiting for earlier ones to finish. Each piece takes a tag, which is an entry in an eight-entry scoreboard.

Responses come back by tag on either port, in any order. The block keeps an outstanding count for each parent. It emits a single acknowledgment for a parent once the parent has been fully split and its count has dropped to zero. A new parent can be split while pieces of earlier parents are still in flight.

Top module: `dss_stripe_splitter`

## Requirements
- R1: While reset is asserted, and after it is released, `loc_valid`, `rmt_valid` and `ack_valid` are low and `req_ready` is high.
- R2: Pieces of one request leave in ascending address order. The first piece starts at the request address, and each later piece starts where the previous one ended. Each piece length is min(remaining bytes, 2048 − (address mod 2048)). The lengths add up to the request length, so no piece crosses an 8 KB slice. The request length is never zero.
- R3: A piece whose address bits [14:13] equal LOCAL_BANK (default 1) appears only on the local port. Any other piece appears only on the remote port, with `rmt_bank` equal to those address bits. The two ports are never valid in the same cycle.
- R4: At most 8 pieces are outstanding. While all 8 tags are in use, neither issue port is valid.
- R5: Every issued tag is one that is not currently outstanding.
- R6: Each accepted request produces exactly one acknowledgment, carrying its ID. The acknowledgment comes only after all of its pieces have been issued and answered.
- R7: Responses are accepted in any order, and the local and remote response ports may both carry a response in the same cycle.
- R8: `req_ready` is high exactly when the previous request has been completely issued. Splitting the next request overlaps with responses still outstanding for earlier ones.
- R9: When several parents finish in the same cycle, their acknowledgments leave one per cycle in consecutive cycles, lowest ID first.
- R10: A piece offered on a port that is not ready keeps its valid, address and length until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Large request offered |
| req_ready | output | 1 | Splitter idle; request taken when both are high |
| req_addr | input | 32 | Start byte address |
| req_len | input | 16 | Length in bytes, nonzero |
| req_id | input | 2 | Parent ID, not reused until acknowledged |
| loc_valid | output | 1 | Piece offered to the local controller |
| loc_ready | input | 1 | Local controller takes the piece |
| loc_addr | output | 32 | Piece address |
| loc_len | output | 16 | Piece length in bytes |
| loc_tag | output | 3 | Scoreboard tag of the piece |
| rmt_valid | output | 1 | Piece offered to the network |
| rmt_ready | input | 1 | Network takes the piece |
| rmt_addr | output | 32 | Piece address |
| rmt_len | output | 16 | Piece length in bytes |
| rmt_tag | output | 3 | Scoreboard tag of the piece |
| rmt_bank | output | 2 | Destination bank |
| loc_rsp_valid | input | 1 | Local completion |
| loc_rsp_tag | input | 3 | Tag completed locally |
| rmt_rsp_valid | input | 1 | Remote completion |
| rmt_rsp_tag | input | 3 | Tag completed remotely |
| ack_valid | output | 1 | One-cycle acknowledgment of a parent |
| ack_id | output | 2 | Parent being acknowledged |

## Verification
Two collisions are targeted. The first is two parents finishing in the same cycle. Responses are held back until one local piece of parent 0 and one remote piece of parent 1 are both outstanding. Both responses are then released on the two ports together. The bench requires the acknowledgment for ID 0 and then ID 1, in consecutive cycles. The second collision is an issue and a response landing on one parent's counter in the same edge. Random ready and response patterns provoke it constantly. Every acknowledgment is judged against the bench's own per-parent counts of pieces still to issue and still unanswered, so a wrong merge of increment and decrement shows up as an early, late or missing acknowledgment.

// File: rtl/dss_pkg.sv
package dss_pkg;

  // Destination of a piece
  typedef enum logic {
    TGT_LOCAL  = 1'b0,
    TGT_REMOTE = 1'b1
  } dss_tgt_e;

endpackage

// File: rtl/dss_cursor.sv
// Walks one large request and presents the current piece.
module dss_cursor #(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 16,
  parameter int CHUNK_LG = 11,
  parameter int PID_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [PID_W-1:0]  req_id,
  input  logic              issue_fire,
  output logic              req_ready,
  output logic              cur_active,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  cur_piece,
  output logic [PID_W-1:0]  cur_id,
  output logic              cur_last
);

  localparam int CHUNK = 1 << CHUNK_LG;

  logic              active_q, active_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [LEN_W-1:0]  rem_q, rem_n;
  logic [PID_W-1:0]  id_q, id_n;
  logic [LEN_W-1:0]  room;
  logic [LEN_W-1:0]  piece;
  logic              load_en;
  logic              step_en;

  // Bytes left before the next chunk boundary
  assign room  = LEN_W'(CHUNK) - LEN_W'(addr_q[CHUNK_LG-1:0]);
  assign piece = (rem_q < room) ? rem_q : room;

  assign load_en = !active_q && req_valid;
  assign step_en = active_q && issue_fire;

  always_comb begin
    active_n = active_q;
    addr_n   = addr_q;
    rem_n    = rem_q;
    id_n     = id_q;
    if (load_en) begin
      active_n = 1'b1;
      addr_n   = req_addr;
      rem_n    = req_len;
      id_n     = req_id;
    end else if (step_en) begin
      addr_n = addr_q + ADDR_W'(piece);
      rem_n  = rem_q - piece;
      if (rem_q == piece) active_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      rem_q    <= '0;
      id_q     <= '0;
    end else if (load_en || step_en) begin
      active_q <= active_n;
      addr_q   <= addr_n;
      rem_q    <= rem_n;
      id_q     <= id_n;
    end
  end

  assign req_ready  = !active_q;
  assign cur_active = active_q;
  assign cur_addr   = addr_q;
  assign cur_piece  = piece;
  assign cur_id     = id_q;
  assign cur_last   = (rem_q == piece);

  // R2: an active walk always has bytes left and a piece of at most one chunk
  p_piece_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (rem_q != '0) && (piece != '0) && (piece <= LEN_W'(CHUNK)));

endmodule

// File: rtl/dss_route.sv
// Steers the current piece to the local or the remote port by its bank bits.
module dss_route
  import dss_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SLICE_LG   = 13,
  parameter int BANK_W     = 2,
  parameter int LOCAL_BANK = 1
) (
  input  logic              cur_active,
  input  logic              has_free,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              loc_ready,
  input  logic              rmt_ready,
  output logic              loc_valid,
  output logic              rmt_valid,
  output logic [BANK_W-1:0] bank,
  output logic              fire
);

  dss_tgt_e tgt;
  logic     issue_ok;

  assign bank     = cur_addr[SLICE_LG+BANK_W-1:SLICE_LG];
  assign tgt      = (bank == BANK_W'(LOCAL_BANK)) ? TGT_LOCAL : TGT_REMOTE;
  assign issue_ok = cur_active && has_free;

  assign loc_valid = issue_ok && (tgt == TGT_LOCAL);
  assign rmt_valid = issue_ok && (tgt == TGT_REMOTE);
  assign fire      = (loc_valid && loc_ready) || (rmt_valid && rmt_ready);

endmodule

// File: rtl/dss_scoreboard.sv
// Tag pool, per-parent outstanding counters and acknowledgment queue.
module dss_scoreboard #(
  parameter int DEPTH   = 8,
  parameter int PARENTS = 4,
  parameter int TAG_W   = $clog2(DEPTH),
  parameter int PID_W   = $clog2(PARENTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [PID_W-1:0] alloc_pid,
  input  logic             alloc_last,
  input  logic             rsp_a_valid,
  input  logic [TAG_W-1:0] rsp_a_tag,
  input  logic             rsp_b_valid,
  input  logic [TAG_W-1:0] rsp_b_tag,
  output logic             has_free,
  output logic [TAG_W-1:0] alloc_tag,
  output logic             ack_valid,
  output logic [PID_W-1:0] ack_id
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]                busy_q, busy_n;
  logic [DEPTH-1:0][PID_W-1:0]     pid_q, pid_n;
  logic [PARENTS-1:0][CNT_W-1:0]   cnt_q, cnt_n;
  logic [PARENTS-1:0]              seal_q, seal_n;
  logic [PARENTS-1:0]              pend_q, pend_n;
  logic [PARENTS-1:0]              done;
  logic [PARENTS-1:0]              ack_hot;
  logic [TAG_W-1:0]                free_tag;
  logic [PID_W-1:0]                pid_a, pid_b;

  // Lowest free tag
  always_comb begin
    free_tag = '0;
    has_free = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        free_tag = TAG_W'(i);
        has_free = 1'b1;
      end
    end
  end

  assign alloc_tag = free_tag;
  assign pid_a     = pid_q[rsp_a_tag];
  assign pid_b     = pid_q[rsp_b_tag];

  // Tag pool next state
  always_comb begin
    busy_n = busy_q;
    pid_n  = pid_q;
    if (rsp_a_valid) busy_n[rsp_a_tag] = 1'b0;
    if (rsp_b_valid) busy_n[rsp_b_tag] = 1'b0;
    if (alloc) begin
      busy_n[free_tag] = 1'b1;
      pid_n[free_tag]  = alloc_pid;
    end
  end

  // One counter and completion detector per parent
  for (genvar p = 0; p < PARENTS; p++) begin : g_parent
    logic       inc;
    logic       hit_a;
    logic       hit_b;
    logic [1:0] dec;
    logic       seal_mid;

    assign inc      = alloc && (alloc_pid == PID_W'(p));
    assign hit_a    = rsp_a_valid && (pid_a == PID_W'(p));
    assign hit_b    = rsp_b_valid && (pid_b == PID_W'(p));
    assign dec      = {1'b0, hit_a} + {1'b0, hit_b};
    assign cnt_n[p] = cnt_q[p] + CNT_W'(inc) - CNT_W'(dec);
    assign seal_mid = seal_q[p] | (inc & alloc_last);
    assign done[p]  = seal_mid && (cnt_n[p] == '0);
    assign seal_n[p] = seal_mid & ~done[p];
  end

  // Acknowledge the lowest pending parent, one per cycle
  always_comb begin
    ack_id  = '0;
    ack_hot = '0;
    for (int p = PARENTS - 1; p >= 0; p--) begin
      if (pend_q[p]) ack_id = PID_W'(p);
    end
    if (|pend_q) ack_hot[ack_id] = 1'b1;
  end

  assign ack_valid = |pend_q;
  assign pend_n    = (pend_q & ~ack_hot) | done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      pid_q  <= '0;
      cnt_q  <= '0;
      seal_q <= '0;
      pend_q <= '0;
    end else begin
      busy_q <= busy_n;
      if (alloc) pid_q <= pid_n;
      cnt_q  <= cnt_n;
      seal_q <= seal_n;
      pend_q <= pend_n;
    end
  end

  // R4: no allocation when every tag is taken
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> has_free);

  // R7: responses name outstanding tags, and two at once name different tags
  p_rsp_known_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_a_valid |-> busy_q[rsp_a_tag]);
  p_rsp_known_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_b_valid |-> busy_q[rsp_b_tag]);
  p_rsp_distinct_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_a_valid && rsp_b_valid) |-> (rsp_a_tag != rsp_b_tag));

  // R6: an acknowledged parent has nothing in flight and nothing left to split
  p_ack_drained_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (cnt_q[ack_id] == '0) && !seal_q[ack_id]);

  // R9: an acknowledged parent leaves the pending set
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> !pend_q[$past(ack_id)]);

endmodule

// File: rtl/dss_stripe_splitter.sv
module dss_stripe_splitter #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int SLICE_LG   = 13,
  parameter int BANK_W     = 2,
  parameter int LOCAL_BANK = 1,
  parameter int CHUNK_LG   = 11,
  parameter int SB_DEPTH   = 8,
  parameter int PARENTS    = 4,
  localparam int TAG_W     = $clog2(SB_DEPTH),
  localparam int PID_W     = $clog2(PARENTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [PID_W-1:0]  req_id,
  output logic              loc_valid,
  input  logic              loc_ready,
  output logic [ADDR_W-1:0] loc_addr,
  output logic [LEN_W-1:0]  loc_len,
  output logic [TAG_W-1:0]  loc_tag,
  output logic              rmt_valid,
  input  logic              rmt_ready,
  output logic [ADDR_W-1:0] rmt_addr,
  output logic [LEN_W-1:0]  rmt_len,
  output logic [TAG_W-1:0]  rmt_tag,
  output logic [BANK_W-1:0] rmt_bank,
  input  logic              loc_rsp_valid,
  input  logic [TAG_W-1:0]  loc_rsp_tag,
  input  logic              rmt_rsp_valid,
  input  logic [TAG_W-1:0]  rmt_rsp_tag,
  output logic              ack_valid,
  output logic [PID_W-1:0]  ack_id
);

  // Reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic              cur_active;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cur_piece;
  logic [PID_W-1:0]  cur_id;
  logic              cur_last;
  logic              has_free;
  logic              fire;
  logic [BANK_W-1:0] bank;
  logic [TAG_W-1:0]  alloc_tag;

  dss_cursor #(
    .ADDR_W  (ADDR_W),
    .LEN_W   (LEN_W),
    .CHUNK_LG(CHUNK_LG),
    .PID_W   (PID_W)
  ) u_cursor (
    .clk       (clk),
    .rst_n     (rst_s),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_id    (req_id),
    .issue_fire(fire),
    .req_ready (req_ready),
    .cur_active(cur_active),
    .cur_addr  (cur_addr),
    .cur_piece (cur_piece),
    .cur_id    (cur_id),
    .cur_last  (cur_last)
  );

  dss_route #(
    .ADDR_W    (ADDR_W),
    .SLICE_LG  (SLICE_LG),
    .BANK_W    (BANK_W),
    .LOCAL_BANK(LOCAL_BANK)
  ) u_route (
    .cur_active(cur_active),
    .has_free  (has_free),
    .cur_addr  (cur_addr),
    .loc_ready (loc_ready),
    .rmt_ready (rmt_ready),
    .loc_valid (loc_valid),
    .rmt_valid (rmt_valid),
    .bank      (bank),
    .fire      (fire)
  );

  dss_scoreboard #(
    .DEPTH  (SB_DEPTH),
    .PARENTS(PARENTS)
  ) u_sb (
    .clk        (clk),
    .rst_n      (rst_s),
    .alloc      (fire),
    .alloc_pid  (cur_id),
    .alloc_last (cur_last),
    .rsp_a_valid(loc_rsp_valid),
    .rsp_a_tag  (loc_rsp_tag),
    .rsp_b_valid(rmt_rsp_valid),
    .rsp_b_tag  (rmt_rsp_tag),
    .has_free   (has_free),
    .alloc_tag  (alloc_tag),
    .ack_valid  (ack_valid),
    .ack_id     (ack_id)
  );

  assign loc_addr = cur_addr;
  assign loc_len  = cur_piece;
  assign loc_tag  = alloc_tag;
  assign rmt_addr = cur_addr;
  assign rmt_len  = cur_piece;
  assign rmt_tag  = alloc_tag;
  assign rmt_bank = bank;

  // R2: requests never carry zero length
  p_len_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_s)
    req_valid |-> (req_len != '0));

  // R10: a stalled piece is held unchanged
  p_hold_loc_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (loc_valid && !loc_ready) |=> loc_valid && $stable(loc_addr) && $stable(loc_len));
  p_hold_rmt_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (rmt_valid && !rmt_ready) |=> rmt_valid && $stable(rmt_addr) && $stable(rmt_len)
                                  && $stable(rmt_bank));

endmodule

// File: tb/sim_dss_stripe_splitter.sv
`timescale 1ns/1ps
module sim_dss_stripe_splitter;

  localparam int LOCAL = 1;
  localparam int CHUNK = 2048;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic [15:0] req_len;
  logic [1:0]  req_id;
  logic        loc_valid, loc_ready, rmt_valid, rmt_ready;
  logic [31:0] loc_addr, rmt_addr;
  logic [15:0] loc_len, rmt_len;
  logic [2:0]  loc_tag, rmt_tag;
  logic [1:0]  rmt_bank;
  logic        loc_rsp_valid, rmt_rsp_valid;
  logic [2:0]  loc_rsp_tag, rmt_rsp_tag;
  logic        ack_valid;
  logic [1:0]  ack_id;

  always #2 clk = ~clk;

  dss_stripe_splitter u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_id(req_id),
    .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_addr(loc_addr),
    .loc_len(loc_len), .loc_tag(loc_tag),
    .rmt_valid(rmt_valid), .rmt_ready(rmt_ready), .rmt_addr(rmt_addr),
    .rmt_len(rmt_len), .rmt_tag(rmt_tag), .rmt_bank(rmt_bank),
    .loc_rsp_valid(loc_rsp_valid), .loc_rsp_tag(loc_rsp_tag),
    .rmt_rsp_valid(rmt_rsp_valid), .rmt_rsp_tag(rmt_rsp_tag),
    .ack_valid(ack_valid), .ack_id(ack_id)
  );

  int checks = 0, fails = 0;
  // expected pieces, pushed by the driver, popped by the monitor
  logic [31:0] e_addr[$];
  int          e_len[$];
  int          e_pid[$];
  // pending large requests
  logic [31:0] q_addr[$];
  int          q_len[$];
  int left[4], outst[4];
  bit busy_id[4];
  bit tbusy[8];
  int tpid[8];
  int lq[$], rq[$];
  bit hold = 0, flush = 0, acc_pend = 0, wd_fired = 0;
  logic [15:0] lfsr = 16'hACE1;
  int cyc = 0, next_id = 0, ack_total = 0, req_total = 0;
  int ack_log_id[$], ack_log_cyc[$];
  bit          stall_seen = 0;
  logic [31:0] stall_addr;
  logic [15:0] stall_len;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_pieces(logic [31:0] addr, int len, int pid);
    logic [31:0] a = addr;
    int r = len;
    int n = 0;
    while (r > 0) begin
      int off = int'(a % CHUNK);
      int p = (r < CHUNK - off) ? r : CHUNK - off;
      e_addr.push_back(a);
      e_len.push_back(p);
      e_pid.push_back(pid);
      a = a + p;
      r = r - p;
      n++;
    end
    left[pid] = n;
  endtask

  task automatic check_issue(bit is_loc, logic [31:0] addr, logic [15:0] len,
                             logic [2:0] tag, logic [1:0] bank, output int pid);
    logic [31:0] ea;
    int el;
    int eb;
    pid = 0;
    if (e_addr.size() == 0) begin
      chk(0, "R2", "unexpected piece addr", addr, 0);
      return;
    end
    ea = e_addr.pop_front();
    el = e_len.pop_front();
    pid = e_pid.pop_front();
    eb = int'(ea[14:13]);
    chk(addr == ea, "R2", "piece address", addr, ea);
    chk(int'(len) == el, "R2", "piece length", len, el);
    chk(is_loc == (eb == LOCAL), "R3", "port is local", is_loc, eb == LOCAL);
    if (!is_loc) chk(int'(bank) == eb, "R3", "remote bank", bank, eb);
    chk(!tbusy[tag], "R5", "tag already outstanding", tag, 0);
    left[pid]--;
    outst[pid]++;
  endtask

  task automatic step();
    int la, lb, busy_cnt, pl, pr;
    bit fl, fr;
    @(negedge clk);
    cyc++;
    if (cyc > 150000) wd_fired = 1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    // request taken at the last edge
    if (acc_pend) begin
      push_pieces(req_addr, int'(req_len), int'(req_id));
      busy_id[req_id] = 1;
      outst[req_id] = 0;
      req_total++;
      req_valid = 0;
      acc_pend = 0;
    end
    // R8: idle exactly when nothing is left to split
    chk(req_ready == (e_addr.size() == 0), "R8", "req_ready", req_ready, e_addr.size() == 0);
    // R6 / R9: acknowledgment monitor
    if (ack_valid) begin
      int id = int'(ack_id);
      chk(busy_id[id] && left[id] == 0 && outst[id] == 0, "R6", "ack before drain",
          {left[id], outst[id]}, 0);
      busy_id[id] = 0;
      ack_total++;
      ack_log_id.push_back(id);
      ack_log_cyc.push_back(cyc);
    end
    // R10: a stalled piece must still be offered unchanged
    if (stall_seen) begin
      chk(loc_valid && loc_addr == stall_addr && loc_len == stall_len, "R10",
          "stalled piece changed", loc_addr, stall_addr);
      stall_seen = 0;
    end
    loc_ready = hold ? 1'b1 : (lfsr[0] | lfsr[3]);
    rmt_ready = hold ? 1'b1 : (lfsr[1] | lfsr[5]);
    if (loc_valid && !loc_ready) begin
      stall_seen = 1;
      stall_addr = loc_addr;
      stall_len = loc_len;
    end
    // R4: full scoreboard blocks issue
    busy_cnt = 0;
    for (int i = 0; i < 8; i++) busy_cnt += tbusy[i];
    if (busy_cnt == 8) chk(!loc_valid && !rmt_valid, "R4", "issue while full", 1, 0);
    if (loc_valid || rmt_valid)
      chk(!(loc_valid && rmt_valid), "R3", "both ports valid", 1, 0);
    // choose responses from outstanding tags
    la = -1;
    lb = -1;
    if (lq.size() > 0 && !hold && (flush || lfsr[2])) begin
      int idx = flush ? 0 : int'(lfsr[9:6]) % lq.size();
      la = lq[idx];
      lq.delete(idx);
    end
    if (rq.size() > 0 && !hold && (flush || lfsr[4])) begin
      int idx = flush ? 0 : int'(lfsr[13:10]) % rq.size();
      lb = rq[idx];
      rq.delete(idx);
    end
    fl = loc_valid && loc_ready;
    fr = rmt_valid && rmt_ready;
    pl = 0;
    pr = 0;
    if (fl) check_issue(1, loc_addr, loc_len, loc_tag, 2'b00, pl);
    if (fr) check_issue(0, rmt_addr, rmt_len, rmt_tag, rmt_bank, pr);
    if (la >= 0) begin tbusy[la] = 0; outst[tpid[la]]--; end
    if (lb >= 0) begin tbusy[lb] = 0; outst[tpid[lb]]--; end
    if (fl) begin tbusy[loc_tag] = 1; tpid[loc_tag] = pl; lq.push_back(int'(loc_tag)); end
    if (fr) begin tbusy[rmt_tag] = 1; tpid[rmt_tag] = pr; rq.push_back(int'(rmt_tag)); end
    loc_rsp_valid = (la >= 0);
    loc_rsp_tag = (la >= 0) ? 3'(la) : 3'd0;
    rmt_rsp_valid = (lb >= 0);
    rmt_rsp_tag = (lb >= 0) ? 3'(lb) : 3'd0;
    // request driver
    if (!req_valid && q_addr.size() > 0 && !busy_id[next_id]) begin
      req_addr = q_addr.pop_front();
      req_len = 16'(q_len.pop_front());
      req_id = 2'(next_id);
      next_id = (next_id + 1) % 4;
      req_valid = 1;
    end
    if (req_valid && req_ready) acc_pend = 1;
  endtask

  function automatic bit idle();
    return q_addr.size() == 0 && !req_valid && !acc_pend &&
           !(busy_id[0] || busy_id[1] || busy_id[2] || busy_id[3]);
  endfunction

  task automatic run_idle();
    while (!idle() && !wd_fired) step();
  endtask

  task automatic add(logic [31:0] a, int l);
    q_addr.push_back(a);
    q_len.push_back(l);
  endtask

  initial begin
    rst_n = 0;
    req_valid = 0; req_addr = 0; req_len = 0; req_id = 0;
    loc_ready = 0; rmt_ready = 0;
    loc_rsp_valid = 0; loc_rsp_tag = 0; rmt_rsp_valid = 0; rmt_rsp_tag = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!loc_valid && !rmt_valid, "R1", "issue valid in reset", {loc_valid, rmt_valid}, 0);
    chk(!ack_valid, "R1", "ack in reset", ack_valid, 0);
    chk(req_ready, "R1", "req_ready in reset", req_ready, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!loc_valid && !rmt_valid && !ack_valid && req_ready, "R1", "state after release",
        {loc_valid, rmt_valid, ack_valid, req_ready}, 1);

    // Directed shapes: R2, R3, R7
    add(32'h0000_2000, 100);
    add(32'h0000_1F00, 'h900);
    add(32'h0000_5ABC, 30000);
    add(32'h0000_7FFF, 1);
    add(32'h0000_2800, CHUNK);
    run_idle();

    // R4: hold responses so ten pieces overrun eight tags
    hold = 1;
    add(32'h0000_0000, 10 * CHUNK);
    repeat (30) step();
    chk(e_addr.size() == 2, "R4", "pieces left while full", e_addr.size(), 2);
    hold = 0;
    run_idle();

    // R9: two parents finish together on both response ports
    next_id = 0;
    hold = 1;
    add(32'h0000_2000, 64);
    add(32'h0000_0000, 64);
    repeat (12) step();
    ack_log_id.delete();
    ack_log_cyc.delete();
    hold = 0;
    flush = 1;
    run_idle();
    flush = 0;
    chk(ack_log_id.size() == 2, "R9", "ack count", ack_log_id.size(), 2);
    if (ack_log_id.size() == 2) begin
      chk(ack_log_id[0] == 0 && ack_log_id[1] == 1, "R9", "ack order",
          {ack_log_id[0], ack_log_id[1]}, {32'd0, 32'd1});
      chk(ack_log_cyc[1] == ack_log_cyc[0] + 1, "R9", "ack spacing",
          ack_log_cyc[1] - ack_log_cyc[0], 1);
    end

    // Mixed random traffic: R2, R3, R5, R6, R7, R8, R10
    for (int k = 0; k < 24; k++) add($urandom_range(0, 32'h0003_FFFF), $urandom_range(1, 9000));
    run_idle();

    chk(ack_total == req_total, "R6", "one ack per request", ack_total, req_total);
    if (wd_fired) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d actual=1 expected=0", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule